// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block keeps the two pieces of floating-point state that software can see: the five accrued-exception flags and the three-bit dynamic rounding mode. A core's CSR access path reaches this state through three address views. One view covers only the flags, one covers only the rounding mode, and one combined word holds both fields. The unit answers each access in the same cycle. It returns read data and an illegal-access indication, and on every successful write it raises a request that the owner of the main status register sets the floating-point state field to Dirty.

Accesses are refused while the floating-point state field reads Off, unless the access is marked as coming from a debugger. Separately from the CSR path, the floating-point datapath can post exception flags on any cycle, and they are ORed into the stored flags. A CSR write that targets the flags in the same cycle overrides the posted flags.

Top module: `fpsr_unit`

## Requirements
- R1: When `fs_state` is 0 (Off) and `dbg_access` is low, any read or write on views 1 to 3 sets `csr_illegal`, returns `csr_rdata` of 0, raises no dirty request and changes no stored field.
- R2: With `dbg_access` high, an access is legal whatever the value of `fs_state`. Any nonzero `fs_state` also makes an access legal.
- R3: `fs_dirty_req` is high in the same cycle as every legal write on views 1 to 3, and low for reads and for refused accesses.
- R4: View select 1 is the flags view. A read returns the flags in bits [4:0] with all higher bits zero. A write stores only `csr_wdata[4:0]`.
- R5: View select 2 is the rounding view. A read returns the rounding mode in bits [2:0] with all higher bits zero. A write stores only `csr_wdata[2:0]`.
- R6: View select 3 is the combined word. A read returns the flags in bits [4:0] and the rounding mode in bits [7:5], with bits above 7 zero.
- R7: A write to the combined word loads the flags from `csr_wdata[4:0]` and the rounding mode from `csr_wdata[7:5]`.
- R8: When `acc_valid` is high, `acc_flags` is ORed into the stored flags at the next clock edge. Flags set this way are never cleared by accumulation.
- R9: A legal write to view 1 or 3 in the same cycle as `acc_valid` stores the written flags and ignores `acc_flags`. A write to view 2 alone leaves the accumulation in effect.
- R10: The rounding mode stores every three-bit value as written, including the reserved values 5, 6 and 7.
- R11: After reset, both the flags and the rounding mode are zero.
- R12: View select 0 addresses nothing. It never raises `csr_illegal` or `fs_dirty_req`, returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_sel | input | 2 | View select: 0 none, 1 flags, 2 rounding, 3 combined |
| csr_rd_en | input | 1 | Read request |
| csr_wr_en | input | 1 | Write request |
| csr_wdata | input | XLEN | Write data |
| dbg_access | input | 1 | Access comes from a debugger, so the Off check is skipped |
| fs_state | input | 2 | Current floating-point state field (0 = Off) |
| acc_valid | input | 1 | Datapath exception flags are valid this cycle |
| acc_flags | input | FLAG_W | Exception flags posted by the datapath |
| csr_rdata | output | XLEN | Read data (current value, before any write this cycle) |
| csr_illegal | output | 1 | Access refused |
| fs_dirty_req | output | 1 | Request to set the floating-point state field to Dirty |

## Verification
`csr_rdata`, `csr_illegal` and `fs_dirty_req` are combinational answers to the request in the same cycle. A write or accumulation becomes visible only after the next rising edge. The bench therefore applies each vector at the falling edge and samples the three outputs 2 ns later, before the rising edge that commits state. Register effects are checked by a read in the following vector. A read that comes with a write is expected to return the value held before that write.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

   typedef enum logic [1:0] {
      VIEW_NONE  = 2'd0,
      VIEW_FLAGS = 2'd1,
      VIEW_ROUND = 2'd2,
      VIEW_FULL  = 2'd3
   } fpsr_view_e;

   localparam logic [1:0] FS_OFF = 2'b00;

endpackage

// File: rtl/fpsr_gate.sv
module fpsr_gate
   import fpsr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  fpsr_view_e sel,
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic       dbg,
   input  logic [1:0] fs,
   output logic       illegal,
   output logic       rd_ok,
   output logic       wr_commit,
   output logic       flags_we,
   output logic       rm_we
);

   logic addressed;
   logic touched;
   logic fs_blocked;

   assign addressed  = (sel != VIEW_NONE);
   assign touched    = addressed && (rd_en || wr_en);
   assign fs_blocked = (fs == FS_OFF) && !dbg;

   assign illegal    = touched && fs_blocked;
   assign rd_ok      = addressed && rd_en && !fs_blocked;
   assign wr_commit  = addressed && wr_en && !fs_blocked;
   assign flags_we   = wr_commit && ((sel == VIEW_FLAGS) || (sel == VIEW_FULL));
   assign rm_we      = wr_commit && ((sel == VIEW_ROUND) || (sel == VIEW_FULL));

   AST_OFF_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (fs == FS_OFF && !dbg && sel != VIEW_NONE && (rd_en || wr_en)) |-> illegal) // R1
      else $error("illegal not raised while Off");

   AST_DBG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      dbg |-> !illegal) // R2
      else $error("debug access refused");

   AST_NO_WRITE_WHEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !(flags_we || rm_we)) // R1
      else $error("write enable on refused access");

   AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == VIEW_NONE) |-> !(illegal || wr_commit || rd_ok)) // R12
      else $error("view 0 produced activity");

endmodule

// File: rtl/fpsr_flag_reg.sv
module fpsr_flag_reg #(
   parameter int FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [FLAG_W-1:0] wdata,
   input  logic              acc_valid,
   input  logic [FLAG_W-1:0] acc_flags,
   output logic [FLAG_W-1:0] flags_q
);

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (we)
            bit_q <= wdata[b];
         else if (acc_valid && acc_flags[b])
            bit_q <= 1'b1;
      end
      assign flags_q[b] = bit_q;
   end

   AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !we) |=> ((flags_q & $past(acc_flags)) == $past(acc_flags))) // R8
      else $error("accumulated flag lost");

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (flags_q == $past(wdata))) // R9
      else $error("flag write not taken");

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !acc_valid) |=> $stable(flags_q)) // R4
      else $error("flags changed without cause");

endmodule

// File: rtl/fpsr_rm_reg.sv
module fpsr_rm_reg #(
   parameter int RM_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RM_W-1:0] wdata,
   output logic [RM_W-1:0] rm_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rm_q <= '0;
      else if (we)
         rm_q <= wdata;
   end

   AST_RM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rm_q == $past(wdata))) // R10
      else $error("rounding mode not stored as written");

   AST_RM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rm_q)) // R5
      else $error("rounding mode changed without write");

endmodule

// File: rtl/fpsr_rdmux.sv
module fpsr_rdmux
   import fpsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int FLAG_W = 5,
   parameter int RM_W   = 3
) (
   input  fpsr_view_e        sel,
   input  logic              rd_ok,
   input  logic [FLAG_W-1:0] flags,
   input  logic [RM_W-1:0]   rm,
   output logic [XLEN-1:0]   rdata
);

   localparam int FULL_W = FLAG_W + RM_W;

   logic [FULL_W-1:0] view_val;

   always_comb begin
      view_val = '0;
      if (rd_ok) begin
         unique case (sel)
            VIEW_FLAGS: view_val[FLAG_W-1:0] = flags;
            VIEW_ROUND: view_val[RM_W-1:0]   = rm;
            VIEW_FULL:  view_val             = {rm, flags};
            default:    view_val             = '0;
         endcase
      end
   end

   if (XLEN > FULL_W) begin : g_pad
      assign rdata = {{(XLEN-FULL_W){1'b0}}, view_val};
   end else begin : g_exact
      assign rdata = view_val;
   end

endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
   import fpsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int FLAG_W = 5,
   parameter int RM_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        csr_sel,
   input  logic              csr_rd_en,
   input  logic              csr_wr_en,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic              dbg_access,
   input  logic [1:0]        fs_state,
   input  logic              acc_valid,
   input  logic [FLAG_W-1:0] acc_flags,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              csr_illegal,
   output logic              fs_dirty_req
);

   localparam int FULL_W = FLAG_W + RM_W;

   if (XLEN < FULL_W) begin : g_bad_xlen
      $error("XLEN too narrow for flags and rounding mode");
   end
   if (FLAG_W < 1 || RM_W < 1) begin : g_bad_field
      $error("field widths must be positive");
   end

   fpsr_view_e        view;
   logic              rd_ok;
   logic              wr_commit;
   logic              flags_we;
   logic              rm_we;
   logic [FLAG_W-1:0] flags_q;
   logic [RM_W-1:0]   rm_q;
   logic [RM_W-1:0]   rm_wdata;

   assign view = fpsr_view_e'(csr_sel);

   fpsr_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (view),
      .rd_en     (csr_rd_en),
      .wr_en     (csr_wr_en),
      .dbg       (dbg_access),
      .fs        (fs_state),
      .illegal   (csr_illegal),
      .rd_ok     (rd_ok),
      .wr_commit (wr_commit),
      .flags_we  (flags_we),
      .rm_we     (rm_we)
   );

   // The combined view places the rounding mode just above the flags.
   assign rm_wdata = (view == VIEW_FULL) ? csr_wdata[FLAG_W +: RM_W]
                                         : csr_wdata[RM_W-1:0];

   fpsr_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (flags_we),
      .wdata     (csr_wdata[FLAG_W-1:0]),
      .acc_valid (acc_valid),
      .acc_flags (acc_flags),
      .flags_q   (flags_q)
   );

   fpsr_rm_reg #(.RM_W(RM_W)) u_rm (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rm_we),
      .wdata (rm_wdata),
      .rm_q  (rm_q)
   );

   fpsr_rdmux #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_rdmux (
      .sel   (view),
      .rd_ok (rd_ok),
      .flags (flags_q),
      .rm    (rm_q),
      .rdata (csr_rdata)
   );

   assign fs_dirty_req = wr_commit;

   AST_REFUSED_KEEPS_RM: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |=> $stable(rm_q)) // R1
      else $error("refused access changed rounding mode");

   AST_DIRTY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fs_dirty_req |-> (csr_wr_en && !csr_illegal)) // R3
      else $error("dirty request without legal write");

   AST_RDATA_ZERO_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == '0)) // R1
      else $error("refused access returned data");

endmodule

// File: tb/test_fpsr_unit.sv
module test_fpsr_unit;

   localparam int XLEN = 32;

   typedef struct packed {
      logic [1:0]  sel;
      logic        rd;
      logic        wr;
      logic [31:0] wd;
      logic        dbg;
      logic [1:0]  fs;
      logic        av;
      logic [4:0]  af;
      logic [31:0] erd;
      logic        eill;
      logic        edty;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h0,  1'b0, 1'b0, 8'd11}, // R11
      '{2'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 2'd1, 1'b0, 5'h00, 32'h0,  1'b0, 1'b1, 8'd4},  // R4
      '{2'd1, 1'b1, 1'b0, 32'h0,         1'b0, 2'd2, 1'b0, 5'h00, 32'h1F, 1'b0, 1'b0, 8'd4},  // R4
      '{2'd2, 1'b0, 1'b1, 32'hFFFF_FFF5, 1'b0, 2'd3, 1'b0, 5'h00, 32'h0,  1'b0, 1'b1, 8'd5},  // R5
      '{2'd2, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h5,  1'b0, 1'b0, 8'd10}, // R10
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'hBF, 1'b0, 1'b0, 8'd6},  // R6
      '{2'd3, 1'b1, 1'b1, 32'hFFFF_FF4A, 1'b0, 2'd3, 1'b0, 5'h00, 32'hBF, 1'b0, 1'b1, 8'd7},  // R7
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h4A, 1'b0, 1'b0, 8'd7},  // R7
      '{2'd1, 1'b1, 1'b1, 32'h1F,        1'b0, 2'd0, 1'b0, 5'h00, 32'h0,  1'b1, 1'b0, 8'd1},  // R1
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b1, 2'd0, 1'b0, 5'h00, 32'h4A, 1'b0, 1'b0, 8'd2},  // R2
      '{2'd2, 1'b0, 1'b1, 32'h6,         1'b1, 2'd0, 1'b0, 5'h00, 32'h0,  1'b0, 1'b1, 8'd3},  // R3
      '{2'd2, 1'b1, 1'b0, 32'h0,         1'b0, 2'd1, 1'b0, 5'h00, 32'h6,  1'b0, 1'b0, 8'd10}, // R10
      '{2'd0, 1'b0, 1'b0, 32'h0,         1'b0, 2'd3, 1'b1, 5'h11, 32'h0,  1'b0, 1'b0, 8'd8},  // R8
      '{2'd1, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h1B, 1'b0, 1'b0, 8'd8},  // R8
      '{2'd1, 1'b0, 1'b1, 32'h4,         1'b0, 2'd3, 1'b1, 5'h01, 32'h0,  1'b0, 1'b1, 8'd9},  // R9
      '{2'd1, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h4,  1'b0, 1'b0, 8'd9},  // R9
      '{2'd2, 1'b0, 1'b1, 32'h1,         1'b0, 2'd3, 1'b1, 5'h10, 32'h0,  1'b0, 1'b1, 8'd9},  // R9
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h34, 1'b0, 1'b0, 8'd9},  // R9
      '{2'd0, 1'b1, 1'b1, 32'hFF,        1'b0, 2'd0, 1'b0, 5'h00, 32'h0,  1'b0, 1'b0, 8'd12}, // R12
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h34, 1'b0, 1'b0, 8'd12}, // R12
      '{2'd2, 1'b1, 1'b0, 32'h0,         1'b0, 2'd0, 1'b0, 5'h00, 32'h0,  1'b1, 1'b0, 8'd1},  // R1
      '{2'd3, 1'b1, 1'b0, 32'h0,         1'b0, 2'd2, 1'b0, 5'h00, 32'h34, 1'b0, 1'b0, 8'd3},  // R3
      '{2'd2, 1'b0, 1'b1, 32'h7,         1'b0, 2'd3, 1'b0, 5'h00, 32'h0,  1'b0, 1'b1, 8'd10}, // R10
      '{2'd2, 1'b1, 1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 5'h00, 32'h7,  1'b0, 1'b0, 8'd10}  // R10
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      csr_sel = '0;
   logic            csr_rd_en = 1'b0;
   logic            csr_wr_en = 1'b0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic            dbg_access = 1'b0;
   logic [1:0]      fs_state = '0;
   logic            acc_valid = 1'b0;
   logic [4:0]      acc_flags = '0;
   logic [XLEN-1:0] csr_rdata;
   logic            csr_illegal;
   logic            fs_dirty_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   fpsr_unit #(.XLEN(XLEN)) i_fpsr_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_sel      (csr_sel),
      .csr_rd_en    (csr_rd_en),
      .csr_wr_en    (csr_wr_en),
      .csr_wdata    (csr_wdata),
      .dbg_access   (dbg_access),
      .fs_state     (fs_state),
      .acc_valid    (acc_valid),
      .acc_flags    (acc_flags),
      .csr_rdata    (csr_rdata),
      .csr_illegal  (csr_illegal),
      .fs_dirty_req (fs_dirty_req)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      csr_sel    = v.sel;
      csr_rd_en  = v.rd;
      csr_wr_en  = v.wr;
      csr_wdata  = v.wd;
      dbg_access = v.dbg;
      fs_state   = v.fs;
      acc_valid  = v.av;
      acc_flags  = v.af;
      #2;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string tag;
         drive(VECS[i]);
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         check(tag, "rdata",   csr_rdata,            VECS[i].erd);
         check(tag, "illegal", {31'b0, csr_illegal}, {31'b0, VECS[i].eill});
         check(tag, "dirty",   {31'b0, fs_dirty_req}, {31'b0, VECS[i].edty});
      end

      // R11: reset in mid-run clears both fields
      drive('{2'd3, 1'b0, 1'b1, 32'hFF, 1'b0, 2'd3, 1'b0, 5'h0, 32'h0, 1'b0, 1'b1, 8'd11});
      @(negedge clk);
      csr_wr_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive('{2'd3, 1'b1, 1'b0, 32'h0, 1'b0, 2'd3, 1'b0, 5'h0, 32'h0, 1'b0, 1'b0, 8'd11});
      check("R11 after reset", "rdata", csr_rdata, 32'h0);

      // R8: accumulation during FS Off still collects datapath flags
      drive('{2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 5'h08, 32'h0, 1'b0, 1'b0, 8'd8});
      drive('{2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 5'h02, 32'h0, 1'b0, 1'b0, 8'd8});
      drive('{2'd1, 1'b1, 1'b0, 32'h0, 1'b0, 2'd1, 1'b0, 5'h00, 32'h0, 1'b0, 1'b0, 8'd8});
      check("R8 two posts", "rdata", csr_rdata, 32'h0A);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule